// File: doc/BRIEF.md
# Output Denormalization Scaler

This stage sits after a colour matrix and turns normalized pixel components into integer codes for the chosen output colour depth. Each clock it may accept one pixel of three components together with a valid strobe. Each component is multiplied by (2^N-1)/2^N, where N is 8, 10 or 12. The product is computed as x minus (x >> N) on the 12-bit normalized value and then rounded to an N-bit code. A 2-bit depth selector chooses N. Selector value 0 leaves the data untouched.

A separate packing bit requests a 10-bit-aligned output format, which is the normal setting. In that format, 8-bit codes are shifted up into the top of a 10-bit field. 10-bit codes pass as they are. 12-bit codes lose their two least significant bits.

Configuration changes take effect only at safe points: in a cycle with no valid pixel, or on a frame-start pulse. A setting can therefore never change in the middle of a line of pixels.

Top module: `dnorm_scaler`

## Requirements
- R1: After synchronous reset, out_valid is 0 and every bit of out_pix is 0.
- R2: With depth selector 0, each output component equals its input component bit for bit, whatever the packing bit is.
- R3: With depth selector 1 and packing 0, the component is s = x - floor(x/256). The output is round-half-up(s/16), an 8-bit code in bits [7:0] with the upper bits zero.
- R4: With depth selector 2 and packing 0, the component is s = x - floor(x/1024). The output is round-half-up(s/4), a 10-bit code in bits [9:0].
- R5: With depth selector 3 and packing 0, the output is x - floor(x/4096), a 12-bit code.
- R6: With packing 1 and a nonzero selector, the 8-bit code appears shifted left by 2 and the 10-bit code appears unchanged. The 12-bit code appears shifted right by 2 and truncated. Bits [11:10] of each component are 0.
- R7: out_valid follows in_valid with one cycle of latency. A result appears one cycle after its input. While in_valid is low, out_pix holds its last value.
- R8: The depth selector and packing bit are taken in any cycle where in_valid is low or frame_start is high, and they apply to that cycle's pixel. In a cycle with in_valid high and frame_start low, the last taken setting is used and the input setting is ignored.
- R9: A full-scale input of 4095 gives the all-ones code for its depth: 255, 1023 or 4095. The rounding never wraps.
- R10: Component k occupies bits [12k+11:12k] of in_pix and out_pix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| frame_start | input | 1 | Frame-start pulse; allows a configuration change during valid data |
| cfg_depth | input | 2 | Depth selector: 0 pass, 1 eight-bit, 2 ten-bit, 3 twelve-bit |
| cfg_pack10 | input | 1 | 1 selects the 10-bit-aligned output format |
| in_pix | input | 36 | Three 12-bit normalized components |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 36 | Three 12-bit output code fields |

## Verification
A wrong held configuration shows at the ports on the first valid pixel after the bad value is taken. That pixel carries codes of the wrong depth or alignment in the very next cycle. Rounding errors show as off-by-one codes in the cycle after the pixel enters, and they are most visible near full scale and at rounding midpoints. A slipped valid pipeline or a lane that updates while idle breaks the one-cycle latency or the hold, and that shows on the next comparison. The stimulus therefore mixes long runs of valid pixels with idle gaps and frame-start pulses. It also changes the selector at random while pixels flow.

// File: rtl/dnorm_pkg.sv
package dnorm_pkg;

    // Depth selector encoding; the values are decoded by every lane.
    typedef enum logic [1:0] {
        DEPTH_PASS = 2'd0,
        DEPTH_8    = 2'd1,
        DEPTH_10   = 2'd2,
        DEPTH_12   = 2'd3
    } depth_sel_e;

    typedef struct packed {
        depth_sel_e depth;
        logic       pack10;
    } dn_cfg_t;

    // Width of the aligned output field when packing is requested.
    localparam int unsigned ALIGN_W = 10;

    function automatic dn_cfg_t make_cfg(input logic [1:0] d, input logic p);
        dn_cfg_t c;
        c.depth  = depth_sel_e'(d);
        c.pack10 = p;
        return c;
    endfunction

endpackage

// File: rtl/dnorm_cfg_gate.sv
module dnorm_cfg_gate
    import dnorm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  logic    frame_start,
    input  dn_cfg_t cfg_req,
    output dn_cfg_t cfg_eff
);

    dn_cfg_t cfg_held;
    logic    take_new;

    // Safe points: idle cycle or frame boundary.
    always_comb begin
        take_new = frame_start || !in_valid;
        cfg_eff  = take_new ? cfg_req : cfg_held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_held <= make_cfg(2'd0, 1'b0);
        end else if (take_new) begin
            cfg_held <= cfg_req;
        end
    end

    // R8: the held setting stays put while pixels flow without a frame pulse
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !frame_start) |=> $stable(cfg_held));

    // R8: a taken setting is what is held afterwards
    a_r8_cfg_taken: assert property (@(posedge clk) disable iff (rst)
        (frame_start || !in_valid) |=> (cfg_held == $past(cfg_req)));

endmodule

// File: rtl/dnorm_lane.sv
module dnorm_lane
    import dnorm_pkg::*;
#(
    parameter int unsigned COMP_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  dn_cfg_t           cfg,
    input  logic [COMP_W-1:0] din,
    output logic [COMP_W-1:0] dout
);

    localparam int unsigned SH8  = COMP_W - 8;
    localparam int unsigned SH10 = COMP_W - 10;
    localparam int unsigned SH12 = COMP_W - 12;

    logic [COMP_W-1:0] s8, s10, s12;
    logic [COMP_W:0]   sum8, sum10, sum12;
    logic [7:0]        c8;
    logic [9:0]        c10;
    logic [11:0]       c12;
    logic [COMP_W-1:0] nxt;

    // Scale by (2^N-1)/2^N as x - (x >> N).
    always_comb begin
        s8  = din - (din >> 8);
        s10 = din - (din >> 10);
        s12 = din - (din >> 12);
        sum8  = {1'b0, s8}  + ((COMP_W+1)'(1) << (SH8 - 1));
        sum10 = {1'b0, s10} + ((COMP_W+1)'(1) << (SH10 - 1));
    end

    generate
        if (SH12 > 0) begin : g_round12
            always_comb sum12 = {1'b0, s12} + ((COMP_W+1)'(1) << (SH12 - 1));
        end else begin : g_exact12
            always_comb sum12 = {1'b0, s12};
        end
    endgenerate

    // Round half up to the target depth.
    always_comb begin
        c8  = sum8[SH8 +: 8];
        c10 = sum10[SH10 +: 10];
        c12 = sum12[SH12 +: 12];
    end

    // Place the code according to the packing bit.
    always_comb begin
        nxt = din;
        unique case (cfg.depth)
            DEPTH_PASS: nxt = din;
            DEPTH_8:    nxt = cfg.pack10 ? COMP_W'({c8, 2'b00}) : COMP_W'(c8);
            DEPTH_10:   nxt = COMP_W'(c10);
            DEPTH_12:   nxt = cfg.pack10 ? COMP_W'(c12[11:2]) : COMP_W'(c12);
            default:    nxt = din;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (ld) begin
            dout <= nxt;
        end
    end

    // R2: pass mode is bit exact
    a_r2_pass_exact: assert property (@(posedge clk) disable iff (rst)
        (ld && cfg.depth == DEPTH_PASS) |=> (dout == $past(din)));

    // R6: packed codes never reach above the aligned field
    a_r6_top_clear: assert property (@(posedge clk) disable iff (rst)
        (ld && cfg.pack10 && cfg.depth != DEPTH_PASS)
            |=> (dout[COMP_W-1:ALIGN_W] == '0));

    // R7: an idle cycle leaves the lane output alone
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(dout));

    // R9: rounding carries never spill past the code width
    a_r9_no_wrap8: assert property (@(posedge clk) disable iff (rst)
        ld |-> !sum8[COMP_W]);
    a_r9_no_wrap10: assert property (@(posedge clk) disable iff (rst)
        ld |-> !sum10[COMP_W]);

endmodule

// File: rtl/dnorm_scaler.sv
module dnorm_scaler
    import dnorm_pkg::*;
#(
    parameter int unsigned COMP_W   = 12,
    parameter int unsigned NUM_COMP = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       frame_start,
    input  logic [1:0]                 cfg_depth,
    input  logic                       cfg_pack10,
    input  logic [NUM_COMP*COMP_W-1:0] in_pix,
    output logic                       out_valid,
    output logic [NUM_COMP*COMP_W-1:0] out_pix
);

    localparam int unsigned BUS_W = NUM_COMP * COMP_W;

    dn_cfg_t cfg_req;
    dn_cfg_t cfg_eff;

    always_comb cfg_req = make_cfg(cfg_depth, cfg_pack10);

    dnorm_cfg_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .cfg_req     (cfg_req),
        .cfg_eff     (cfg_eff)
    );

    generate
        for (genvar k = 0; k < NUM_COMP; k++) begin : g_lane
            dnorm_lane #(.COMP_W(COMP_W)) u_lane (
                .clk  (clk),
                .rst  (rst),
                .ld   (in_valid),
                .cfg  (cfg_eff),
                .din  (in_pix[k*COMP_W +: COMP_W]),
                .dout (out_pix[k*COMP_W +: COMP_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // R7: valid moves through in step with the data
    a_r7_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r7_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1: reset clears the bus (checked one cycle into reset)
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (out_pix == BUS_W'(0) && !out_valid));

endmodule

// File: tb/test_dnorm_scaler.sv
module test_dnorm_scaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        frame_start = 1'b0;
    logic [1:0]  cfg_depth = 2'd0;
    logic        cfg_pack10 = 1'b0;
    logic [35:0] in_pix = '0;
    logic        out_valid;
    logic [35:0] out_pix;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0]  m_depth = 2'd0;
    logic        m_pack = 1'b0;
    logic [35:0] exp_pix = '0;

    always #4 clk = ~clk;

    dnorm_scaler i_dnorm_scaler (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .cfg_depth   (cfg_depth),
        .cfg_pack10  (cfg_pack10),
        .in_pix      (in_pix),
        .out_valid   (out_valid),
        .out_pix     (out_pix)
    );

    function automatic logic [11:0] ref_code(input logic [1:0] d, input logic p,
                                             input logic [11:0] x);
        int n, s, sh, r;
        if (d == 2'd0) return x;
        n  = (d == 2'd1) ? 8 : (d == 2'd2) ? 10 : 12;
        s  = int'(x) - (int'(x) >> n);
        sh = 12 - n;
        r  = (sh > 0) ? ((s + (1 << (sh - 1))) >> sh) : s;
        if (p) r = (n < 10) ? (r << (10 - n)) : (r >> (n - 10));
        return 12'(r);
    endfunction

    function automatic string auto_tag(input logic [1:0] d, input logic p);
        if (d == 2'd0) return "R2";
        if (p) return "R6";
        if (d == 2'd1) return "R3";
        if (d == 2'd2) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit fs, input logic [1:0] d, input logic p,
                        input logic [11:0] a, input logic [11:0] b, input logic [11:0] c,
                        input string tag);
        string t;
        @(negedge clk);
        in_valid = v; frame_start = fs; cfg_depth = d; cfg_pack10 = p;
        in_pix = {c, b, a};   // R10: component 0 in the low field
        if (fs || !v) begin m_depth = d; m_pack = p; end
        if (v) exp_pix = {ref_code(m_depth, m_pack, c), ref_code(m_depth, m_pack, b),
                          ref_code(m_depth, m_pack, a)};
        t = (tag == "") ? (v ? auto_tag(m_depth, m_pack) : "R7") : tag;
        @(posedge clk); #1;
        chk("R7", {35'd0, out_valid}, {35'd0, v});
        chk(t, out_pix, exp_pix);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {35'd0, out_valid}, 36'd0);
        chk("R1", out_pix, 36'd0);
        @(negedge clk); rst = 1'b0;

        // R2 pass through, both packing settings
        step(0, 0, 2'd0, 1'b1, 12'h000, 12'h000, 12'h000, "R7");
        step(1, 0, 2'd0, 1'b1, 12'hABC, 12'hFFF, 12'h001, "R2");
        step(1, 1, 2'd0, 1'b0, 12'h123, 12'h800, 12'h7FF, "R2");
        // R3, R4, R5 unpacked with midpoints and zero
        step(1, 1, 2'd1, 1'b0, 12'd2048, 12'd0, 12'd8, "R3");
        step(1, 1, 2'd2, 1'b0, 12'd2050, 12'd1, 12'd2, "R4");
        step(1, 1, 2'd3, 1'b0, 12'd4000, 12'd17, 12'd3, "R5");
        // R9 full scale at every depth, both packings
        step(1, 1, 2'd1, 1'b0, 12'hFFF, 12'hFFF, 12'hFFF, "R9");
        step(1, 1, 2'd2, 1'b0, 12'hFFF, 12'hFFE, 12'hFFD, "R9");
        step(1, 1, 2'd3, 1'b0, 12'hFFF, 12'hFFF, 12'hFFF, "R9");
        step(1, 1, 2'd1, 1'b1, 12'hFFF, 12'h010, 12'h7F8, "R6");
        step(1, 1, 2'd2, 1'b1, 12'hFFF, 12'h3FF, 12'h400, "R6");
        step(1, 1, 2'd3, 1'b1, 12'hFFF, 12'h003, 12'h806, "R6");
        // R7 hold while idle (idle also takes the new setting)
        step(0, 0, 2'd1, 1'b0, 12'h555, 12'h555, 12'h555, "R7");
        step(0, 0, 2'd1, 1'b0, 12'h0AA, 12'h0AA, 12'h0AA, "R7");
        // R8 setting ignored mid-line, taken at frame start
        step(1, 0, 2'd1, 1'b0, 12'd1000, 12'd3000, 12'd77, "R8");
        step(1, 0, 2'd2, 1'b1, 12'd1000, 12'd3000, 12'd77, "R8");
        step(1, 0, 2'd0, 1'b1, 12'd1234, 12'd4095, 12'd9, "R8");
        step(1, 1, 2'd2, 1'b1, 12'd1000, 12'd3000, 12'd77, "R8");
        step(1, 0, 2'd1, 1'b0, 12'd1000, 12'd3000, 12'd77, "R8");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            bit v, fs;
            logic [1:0] d;
            logic p;
            v  = ($urandom % 4) != 0;
            fs = ($urandom % 10) == 0;
            d  = 2'($urandom % 4);
            p  = 1'($urandom % 2);
            step(v, fs, d, p, 12'($urandom), 12'($urandom), 12'($urandom), "");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule